// File: doc/BRIEF.md
# Converter Serial Readout Port with Read-Error Flag

This block is the digital output side of a sampling converter that an external host reads with its own serial clock. A one-cycle convert strobe starts a conversion. A busy output then stays high for a fixed number of system clock cycles. While busy is high, the host pulls chip-select and read low and clocks out the result of the previous conversion, one bit per serial clock pulse, most significant bit first. The falling edge of busy tells the host that the conversion has ended.

At the end of each conversion the new sample is copied into the output word and the bit position returns to the first bit. If the host has not clocked out all 16 bits by then, a one-cycle read-error pulse is raised, which the host can use as an interrupt. The serial clock, chip-select and read inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and serial clock edges are detected after it. A stub stands in for the analog part and supplies the sample values. Conversion n, counting from 1 after reset, yields BASE + (n-1)*STEP modulo 2^16.

Top module: `convReadout`

## Requirements
- R1: A convert strobe sampled high while busy is low makes busy go high on the next clock edge. Busy then stays high for exactly CONV_CYCLES system clock cycles.
- R2: A convert strobe that arrives while busy is high has no effect. Busy falls CONV_CYCLES cycles after the strobe that started the conversion.
- R3: While busy is high and chip-select and read are both low, the word shifted out is the result of the previous completed conversion. It goes out MSB first, and each synchronized rising edge of the serial clock advances one bit. Before the first completed conversion, that result is 0.
- R4: The serial data output changes only after a serial clock rising edge. Each bit therefore holds over the whole clock period, through both the falling edge and the rising edge that ends it.
- R5: Once all 16 bits have been shifted out, the data output stays 0 for further clock pulses until the next conversion ends.
- R6: A rising edge of chip-select resets the bit position, so the next read starts again at the MSB.
- R7: When busy falls and fewer than 16 bits have been counted since the last reset of the bit position, rdErr is high for exactly one cycle, in the same cycle busy is first low. It is low at every other time.
- R8: When busy falls, the stub's new sample is copied into the output word and the bit position is cleared, even if the previous read was incomplete. With chip-select and read still low, the MSB of the new word appears at once.
- R9: Serial clock pulses have no effect on the bit position while busy is low, or while read is high. Chip-select and read gate the data output, which is 0 unless both are low.
- R10: After reset, busy, sdo and rdErr are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| convStart | input | 1 | One-cycle convert strobe, system clock domain |
| csN | input | 1 | Active-low chip-select, asynchronous |
| rdN | input | 1 | Active-low read enable, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| busy | output | 1 | High while a conversion is in progress |
| sdo | output | 1 | Serial data out, MSB first |
| rdErr | output | 1 | One-cycle pulse when a read did not finish before busy fell |

## Verification
The case hardest to reach from the ports is an incomplete read that is still in progress when busy falls. That case must raise the error pulse and must also hand over the new word starting at its MSB without a chip-select toggle. The stimulus clocks seven bits out, leaves chip-select and read low through the end of the conversion, then checks the error cycle and the new MSB straight away. A second sequence abandons a read with a chip-select rise and restarts it. A third clocks the serial line while read is high and while busy is low. The later reads then show that none of these pulses moved the bit position.

// File: rtl/convReadoutPkg.sv
package convReadoutPkg;
  typedef struct packed {
    logic latchNew;  // end of conversion: take new sample, clear position
    logic restart;   // chip-select rose: clear position
    logic advance;   // synchronized serial clock rising edge while enabled
    logic drive;     // chip-select and read both low
  } strobe_t;
endpackage

// File: rtl/convSampleStub.sv
module convSampleStub #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] BASE = 16'hA5C3,
  parameter logic [DATA_W-1:0] STEP = 16'h1357
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              take,
  output logic [DATA_W-1:0] sample
);
  always_ff @(posedge clk) begin
    if (!rstN) sample <= BASE;
    else if (take) sample <= sample + STEP;
  end
endmodule

// File: rtl/convReadoutCtrl.sv
module convReadoutCtrl
  import convReadoutPkg::*;
#(
  parameter int CONV_CYCLES = 300
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    convStart,
  input  logic    csN,
  input  logic    rdN,
  input  logic    sclk,
  input  logic    wordDone,
  output logic    busy,
  output logic    rdErr,
  output strobe_t strb
);
  localparam int CW = (CONV_CYCLES < 2) ? 1 : $clog2(CONV_CYCLES);

  logic [CW-1:0] convLeft;
  logic [2:0] csSync, sclkSync;
  logic [1:0] rdSync;
  logic endConv, enable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csSync   <= 3'b111;
      rdSync   <= 2'b11;
      sclkSync <= 3'b000;
    end else begin
      csSync   <= {csSync[1:0], csN};
      rdSync   <= {rdSync[0], rdN};
      sclkSync <= {sclkSync[1:0], sclk};
    end
  end

  assign enable  = !csSync[1] && !rdSync[1];
  assign endConv = busy && (convLeft == '0);

  always_comb begin
    strb.latchNew = endConv;
    strb.restart  = csSync[1] && !csSync[2];
    strb.advance  = busy && enable && sclkSync[1] && !sclkSync[2];
    strb.drive    = enable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      convLeft <= '0;
      rdErr    <= 1'b0;
    end else begin
      rdErr <= endConv && !wordDone;
      if (busy) begin
        if (endConv) busy <= 1'b0;
        else convLeft <= convLeft - 1'b1;
      end else if (convStart) begin
        busy     <= 1'b1;
        convLeft <= CW'(CONV_CYCLES - 1);
      end
    end
  end

  // R1
  busyRise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(convStart));
  // R7
  errAtEnd_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> $fell(busy));
  // R7
  errPulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |=> !rdErr);
endmodule

// File: rtl/convReadoutPath.sv
module convReadoutPath
  import convReadoutPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              wordDone,
  output logic              sdo
);
  localparam int PW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] result, shifted;
  logic [PW-1:0] bitPos;

  assign wordDone = (bitPos == PW'(DATA_W));
  assign shifted  = result << bitPos;
  assign sdo      = strb.drive && shifted[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      bitPos <= '0;
    end else if (strb.latchNew) begin
      result <= sampleIn;
      bitPos <= '0;
    end else if (strb.restart) begin
      bitPos <= '0;
    end else if (strb.advance && !wordDone) begin
      bitPos <= bitPos + 1'b1;
    end
  end

  // R8
  latchTake_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchNew |=> (result == $past(sampleIn)) && (bitPos == '0));
  // R5
  tailZero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |-> !sdo);
endmodule

// File: rtl/convReadout.sv
module convReadout
  import convReadoutPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CONV_CYCLES = 300,
  parameter logic [DATA_W-1:0] BASE = 16'hA5C3,
  parameter logic [DATA_W-1:0] STEP = 16'h1357
) (
  input  logic clk,
  input  logic rstN,
  input  logic convStart,
  input  logic csN,
  input  logic rdN,
  input  logic sclk,
  output logic busy,
  output logic sdo,
  output logic rdErr
);
  strobe_t strb;
  logic wordDone;
  logic [DATA_W-1:0] sample;

  convReadoutCtrl #(.CONV_CYCLES(CONV_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .convStart(convStart), .csN(csN), .rdN(rdN),
    .sclk(sclk), .wordDone(wordDone), .busy(busy), .rdErr(rdErr), .strb(strb)
  );

  convReadoutPath #(.DATA_W(DATA_W)) path (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleIn(sample),
    .wordDone(wordDone), .sdo(sdo)
  );

  convSampleStub #(.DATA_W(DATA_W), .BASE(BASE), .STEP(STEP)) stub (
    .clk(clk), .rstN(rstN), .take(strb.latchNew), .sample(sample)
  );
endmodule

// File: tb/convReadout_test.sv
`timescale 1ns/1ps
module convReadout_test;
  localparam int CONV = 300;
  localparam int HALF = 4;
  localparam logic [15:0] BASE = 16'hA5C3;
  localparam logic [15:0] STEP = 16'h1357;

  logic clk = 0, rstN = 0, convStart = 0, csN = 1, rdN = 1, sclk = 0;
  logic busy, sdo, rdErr;
  int vectors = 0, fails = 0;
  int mLeft = 0, readCount = 0, completed = 0, errSeen = 0;
  bit mBusy = 0, mErr = 0, checking = 0, finished = 0;

  always #4 clk = ~clk;

  convReadout #(.CONV_CYCLES(CONV), .BASE(BASE), .STEP(STEP)) uut (
    .clk(clk), .rstN(rstN), .convStart(convStart), .csN(csN), .rdN(rdN),
    .sclk(sclk), .busy(busy), .sdo(sdo), .rdErr(rdErr));

  // behavioural reference: conversion timing and error decision
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mLeft = 0; mErr = 0;
    end else begin
      mErr = 0;
      if (mBusy) begin
        mLeft--;
        if (mLeft == 0) begin
          mBusy = 0;
          mErr = (readCount < 16);
          if (mErr) errSeen++;
          readCount = 0;
          completed++;
        end
      end else if (convStart) begin
        mBusy = 1; mLeft = CONV;
      end
    end
  end

  always @(negedge clk) if (checking) begin
    vectors++;
    if (busy !== mBusy) begin
      fails++; $display("FAIL R1/R2 busy: actual %0b expected %0b", busy, mBusy);
    end
    vectors++;
    if (rdErr !== mErr) begin
      fails++; $display("FAIL R7 rdErr: actual %0b expected %0b", rdErr, mErr);
    end
  end

  function automatic logic [15:0] prevWord();
    return (completed == 0) ? 16'h0 : 16'(BASE + 16'(completed - 1) * STEP);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++; $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startConv();
    @(negedge clk); convStart = 1;
    @(negedge clk); convStart = 0;
  endtask

  task automatic waitEnd();
    while (mBusy) @(negedge clk);
    cycles(2);
  endtask

  // n pulses; counted=1 when the design should advance
  task automatic pulses(input int n, input logic [15:0] w, input int startBit,
                        input bit counted, input string tag);
    for (int i = 0; i < n; i++) begin
      int b = counted ? startBit + i : startBit;
      int nb = counted ? b + 1 : b;
      check(sdo, (b < 16) ? w[15-b] : 1'b0, tag);
      sclk = 1;
      if (counted && readCount < 16) readCount++;
      cycles(HALF);
      check(sdo, (nb < 16) ? w[15-nb] : 1'b0, "R4 held across falling edge");
      sclk = 0;
      cycles(HALF);
    end
  endtask

  task automatic csLow(input logic rd);
    csN = 0; rdN = rd; cycles(8);
  endtask

  task automatic csHigh();
    csN = 1; rdN = 1; readCount = 0; cycles(8);
  endtask

  initial begin
    logic [15:0] w;
    int e0;
    cycles(4);
    check(busy, 1'b0, "R10 busy reset"); check(sdo, 1'b0, "R10 sdo reset");
    check(rdErr, 1'b0, "R10 rdErr reset");
    rstN = 1; checking = 1; cycles(3);

    // conversion 1, nothing read: error expected (R7)
    e0 = errSeen; startConv(); waitEnd();
    check(errSeen != e0, 1'b1, "R7 unread conversion flags error");

    // conversion 2: extra strobe while busy (R2), full read (R3) and tail (R5)
    startConv(); cycles(20);
    convStart = 1; @(negedge clk); convStart = 0;
    w = prevWord(); csLow(1'b0);
    pulses(16, w, 0, 1, "R3 word MSB first");
    pulses(3, w, 16, 1, "R5 zero after last bit");
    e0 = errSeen; waitEnd();
    check(errSeen != e0, 1'b0, "R7 full read no error");
    csHigh();

    // conversion 3: abandon after 5 bits, restart from MSB (R6)
    startConv(); w = prevWord(); csLow(1'b0);
    pulses(5, w, 0, 1, "R3 partial read");
    csHigh(); csLow(1'b0);
    pulses(16, w, 0, 1, "R6 restart at MSB");
    e0 = errSeen; waitEnd();
    check(errSeen != e0, 1'b0, "R6 restarted read complete");
    csHigh();

    // conversion 4: read high blocks advance (R9), then 7 bits only (R7)
    startConv(); w = prevWord(); csLow(1'b1);
    check(sdo, 1'b0, "R9 read high gates output");
    pulses(6, 16'h0, 16, 0, "R9 read high no output");
    rdN = 0; cycles(8);
    pulses(7, w, 0, 1, "R9 no advance with read high");
    e0 = errSeen; waitEnd();
    check(errSeen != e0, 1'b1, "R7 incomplete read flags error");
    w = prevWord();
    check(sdo, w[15], "R8 new MSB right after busy falls");

    // idle pulses do not advance (R9); conversion 5 reads the new word (R8)
    pulses(5, w, 0, 0, "R9 idle pulses no advance");
    startConv(); cycles(4);
    pulses(16, w, 0, 1, "R8 new sample after incomplete read");
    pulses(1, w, 16, 1, "R5 zero after last bit");
    waitEnd(); csHigh();

    checking = 0; finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule